// File: doc/BRIEF.md
# Dual-Enable Static RAM Model

This block is a clocked stand-in for a byte-wide asynchronous static RAM. It lets a memory controller bench talk to a realistic target. Access needs two enables: an active-low one (`en_n`) and an active-high one (`en_h`). An active-low output enable (`oe_n`) and an active-low write strobe (`wr_n`) then pick the operation. The shared data bus is split into `din`, `dout` and `drive_en`. Reads are combinational: the addressed word appears on `dout` in the same cycle. Writes follow overlap semantics. A word is written only when the enables and the write strobe are all active together. It is committed on the clock sample where that overlap ends.

A timing monitor counts clock samples and raises flags for four conditions:
- a read taken too soon after the address or the selection changed;
- a write overlap that is too short;
- an address that moves during a write;
- an address that is held for too few samples.

After reset, storage that has never been written returns a pattern derived from its address. A checking bench can therefore tell unwritten words from written ones. The address width is a parameter. The default of 11 bits (2048 words) keeps elaboration light, and `ADDR_W=13` gives the full 8192-word organisation.

Top module: `dsram`

## Requirements
- R1: When `en_n` is high or `en_h` is low, `drive_en` is 0 and a low `wr_n` writes nothing.
- R2: With `en_n`=0, `en_h`=1, `wr_n`=1 and `oe_n`=0, `drive_en` is 1 and `dout` shows the word at `addr` in the same cycle.
- R3: `drive_en` is 0 whenever `oe_n` is high or `wr_n` is low, including during a write with `oe_n` low.
- R4: A write commits on the first clock sample at which the overlap (`en_n`=0, `en_h`=1, `wr_n`=0) is no longer present. It uses the address and data from the last sample inside the overlap. The overlap may end by `wr_n` rising or by deselection, and the level of `oe_n` does not matter.
- R5: When `en_n` and `wr_n` rise together with `oe_n` low, `drive_en` stays 0 and the write still commits.
- R6: An overlap lasting fewer than `T_PW` samples commits nothing. It sets `viol_pw` for exactly one cycle after the sample at which it ends.
- R7: After reset, all flags are 0, `drive_en` is 0, and a never-written word reads as `addr[7:0] ^ 8'hA5`.
- R8: `rd_stale` is 1 while driving if `addr` or the selection changed since the last sample, or if fewer than `T_ACC` samples have passed since that change. It is 0 from the `T_ACC`-th sample on.
- R9: `viol_setup` is 1 for one cycle after a sample that sees a different address from the previous sample while both samples lie inside one overlap.
- R10: `viol_cyc` is 1 for one cycle after a sample that sees an address change when the previous address was held for fewer than `T_CYC` samples. A hold of exactly `T_CYC` samples raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address |
| en_n | input | 1 | Active-low chip enable |
| en_h | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Data from the bus |
| dout | output | 8 | Data toward the bus |
| drive_en | output | 1 | Bus driver enable |
| rd_stale | output | 1 | Read data not yet valid |
| viol_pw | output | 1 | Write overlap too short |
| viol_setup | output | 1 | Address moved inside a write |
| viol_cyc | output | 1 | Address held too briefly |

## Verification
The hardest case is the write that ends because the chip enable and the write strobe rise in the same cycle while `oe_n` is already low. It has to show no drive and still commit. The bench reaches it with a vector that ends its write by deselection, and with a directed write that holds `oe_n` low throughout. Readback then confirms the commit. The monitor flags are reached by directed sequences: an address moved between two samples of one overlap, and address changes one sample apart set against a hold of exactly `T_CYC` samples.

// File: rtl/dsram.sv
module dsram #(
  parameter int ADDR_W = 11,
  parameter int T_ACC  = 2,
  parameter int T_PW   = 2,
  parameter int T_CYC  = 3,
  parameter logic [7:0] PAT = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              en_h,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              drive_en,
  output logic              rd_stale,
  output logic              viol_pw,
  output logic              viol_setup,
  output logic              viol_cyc
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(T_ACC + T_PW + T_CYC + 1) + 1;

  logic [7:0]        mem [DEPTH];
  logic [DEPTH-1:0]  filled;
  logic              sel_q, wov_q;
  logic [ADDR_W-1:0] addr_q, wa_q;
  logic [7:0]        wd_q;
  logic [CW-1:0]     age, a_age, pw;

  wire sel      = !en_n && en_h;
  wire wov      = sel && !wr_n;
  wire addr_chg = addr != addr_q;
  wire evt      = addr_chg || (sel && !sel_q);
  wire wend     = wov_q && !wov;
  wire wok      = wend && (pw >= CW'(T_PW));

  assign drive_en = sel && wr_n && !oe_n;
  assign dout     = filled[addr] ? mem[addr] : (8'(addr) ^ PAT);
  assign rd_stale = drive_en && (evt || age < CW'(T_ACC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      wov_q      <= 1'b0;
      addr_q     <= '0;
      wa_q       <= '0;
      wd_q       <= '0;
      age        <= '0;
      a_age      <= CW'(T_CYC);
      pw         <= '0;
      filled     <= '0;
      viol_pw    <= 1'b0;
      viol_setup <= 1'b0;
      viol_cyc   <= 1'b0;
    end else begin
      sel_q  <= sel;
      wov_q  <= wov;
      addr_q <= addr;
      if (evt)                    age <= '0;
      else if (age < CW'(T_ACC))  age <= age + 1'b1;
      if (addr_chg)               a_age <= '0;
      else if (a_age < CW'(T_CYC)) a_age <= a_age + 1'b1;
      if (wov) begin
        wa_q <= addr;
        wd_q <= din;
        if (!wov_q)                pw <= CW'(1);
        else if (pw < CW'(T_PW))   pw <= pw + 1'b1;
      end
      if (wok) filled[wa_q] <= 1'b1;
      viol_pw    <= wend && !wok;
      viol_setup <= wov && wov_q && addr_chg;
      viol_cyc   <= addr_chg && (a_age < CW'(T_CYC - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wok) mem[wa_q] <= wd_q;
  end
endmodule

module dsram_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              en_n,
  input logic              en_h,
  input logic              oe_n,
  input logic              wr_n,
  input logic              drive_en,
  input logic              rd_stale,
  input logic              viol_pw,
  input logic              viol_setup,
  input logic              viol_cyc
);
  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n || !en_h) |-> !drive_en);
  assert_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || oe_n) |-> !drive_en);
  assert_pw_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pw |=> !viol_pw);
  assert_stale_on_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && addr != $past(addr)) |-> rd_stale);
  assert_setup_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_setup |-> $past(!wr_n && !en_n && en_h));
  assert_cyc_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_cyc |-> $past(addr) != $past(addr, 2));
endmodule

bind dsram dsram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dsram_tb.sv
module dsram_tb;
  localparam int AW = 11;
  localparam int T_ACC = 2;
  localparam int T_PW = 2;
  localparam int T_CYC = 3;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic en_n = 1, en_h = 0, oe_n = 1, wr_n = 1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic drive_en, rd_stale, viol_pw, viol_setup, viol_cyc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dsram #(.ADDR_W(AW), .T_ACC(T_ACC), .T_PW(T_PW), .T_CYC(T_CYC)) u_dut (.*);

  // vector: [24] end by deselect, [23] write, [22:12] addr, [11:4] data / expected, [3:0] overlap length
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 1'b1, 11'h005, 8'h3C, 4'd2},
    {1'b1, 1'b1, 11'h7FF, 8'hC3, 4'd3},
    {1'b0, 1'b1, 11'h100, 8'h55, 4'd1},
    {1'b0, 1'b0, 11'h005, 8'h3C, 4'd0},
    {1'b0, 1'b0, 11'h7FF, 8'hC3, 4'd0},
    {1'b0, 1'b0, 11'h100, 8'hA5, 4'd0},
    {1'b0, 1'b0, 11'h033, 8'h96, 4'd0},
    {1'b1, 1'b1, 11'h005, 8'h81, 4'd2},
    {1'b0, 1'b0, 11'h005, 8'h81, 4'd0},
    {1'b0, 1'b0, 11'h0FF, 8'h5A, 4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input int len,
                          input logic oe, input logic ce_end);
    @(negedge clk);
    addr = a; din = d; en_n = 0; en_h = 1; wr_n = 0; oe_n = oe;
    #1 chk("R3 no drive during write", drive_en, 0);
    repeat (len) @(posedge clk);
    @(negedge clk);
    wr_n = 1;
    if (ce_end) en_n = 1; else oe_n = 1;
    #1 chk("R5/R3 no drive at write end", drive_en, 0);
    @(posedge clk);
    #1 chk("R6 short-overlap flag", viol_pw, (len < T_PW) ? 1 : 0);
    @(negedge clk);
    en_n = 1; oe_n = 1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] e);
    @(negedge clk);
    addr = a; en_n = 0; en_h = 1; wr_n = 1; oe_n = 0;
    #1 chk("R2 drive on read", drive_en, 1);
    chk("R2/R4/R7 read data", dout, e);
    chk("R8 stale right after change", rd_stale, 1);
    repeat (T_ACC) @(posedge clk);
    #1 chk("R8 stale before access count", rd_stale, 1);
    @(posedge clk);
    #1 chk("R8 valid at access count", rd_stale, 0);
    @(negedge clk);
    en_n = 1; oe_n = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 chk("R7 reset drive", drive_en, 0);
    chk("R7 reset flags", {viol_pw, viol_setup, viol_cyc}, 0);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][23]) do_write(VEC[i][22:12], VEC[i][11:4], int'(VEC[i][3:0]), 1'b1, VEC[i][24]);
      else            do_read(VEC[i][22:12], VEC[i][11:4]);
    end

    // R1 deselection by either enable
    @(negedge clk);
    addr = 11'h005; en_n = 1; en_h = 1; oe_n = 0; wr_n = 1;
    #1 chk("R1 en_n high no drive", drive_en, 0);
    @(negedge clk) begin en_n = 0; en_h = 0; end
    #1 chk("R1 en_h low no drive", drive_en, 0);
    @(negedge clk) begin en_h = 1; oe_n = 1; end
    #1 chk("R3 oe_n high no drive", drive_en, 0);

    // R1 write attempt while deselected is ignored
    @(negedge clk) begin en_h = 0; wr_n = 0; din = 8'hEE; oe_n = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk) begin wr_n = 1; en_n = 1; end
    @(posedge clk);
    #1 chk("R1 deselected write no flag", viol_pw, 0);
    do_read(11'h005, 8'h81);

    // R4/R5 write with oe_n low, ended by simultaneous deselect and strobe rise
    do_write(11'h222, 8'h5A, 3, 1'b0, 1'b1);
    do_read(11'h222, 8'h5A);

    // R9 address moved inside an overlap; last sampled address commits
    @(negedge clk) begin addr = 11'h300; din = 8'h11; en_n = 0; en_h = 1; wr_n = 0; oe_n = 1; end
    @(posedge clk);
    @(negedge clk) addr = 11'h301;
    @(posedge clk);
    #1 chk("R9 setup flag", viol_setup, 1);
    @(negedge clk) wr_n = 1;
    @(posedge clk);
    #1 chk("R9 setup flag clears", viol_setup, 0);
    @(negedge clk) en_n = 1;
    do_read(11'h301, 8'h11);
    do_read(11'h300, 8'hA5);

    // R10 cycle time: exact hold passes, single-sample hold flags
    @(negedge clk) begin addr = 11'h010; en_n = 0; en_h = 1; oe_n = 0; wr_n = 1; end
    repeat (T_CYC) @(posedge clk);
    @(negedge clk) addr = 11'h011;
    @(posedge clk);
    #1 chk("R10 exact hold no flag", viol_cyc, 0);
    @(negedge clk) addr = 11'h012;
    @(posedge clk);
    #1 chk("R10 short hold flag", viol_cyc, 1);
    @(negedge clk) begin en_n = 1; oe_n = 1; end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule